// File: doc/BRIEF.md
# Frame-Synchronous PWM Pin Generator

This block drives one pin with a pulse-width modulated waveform. A configuration pulse sets the frame length and, optionally, a starting on-count. From the next clock on, the block runs by itself. Each frame starts with the pin high for the on-count number of clocks, and the pin is low for the rest of the frame. A flag marks the first clock of every frame. Software can wait on that flag, and because every pin configured in the same cycle counts in lockstep, a single edge stands for all of them.

New on-counts arrive as a serial word on a one-wire data input. The word is a high start bit, then 16 data bits with the most significant bit first, then a low stop bit: 18 clocks in all. A received value goes into a holding buffer and is applied only when the next frame begins. If no new word arrives, the block repeats the previous value. When the mode enable drops, the block releases the pin to its plain output value on the next clock.

The serial input is a stream without a ready signal, so the block can apply no back-pressure. The sender is responsible for the 18-clock framing and should keep the line low between words. A line that is high while the receiver is idle begins a word. A later good word replaces an earlier one that has not yet been applied.

Top module: `frame_pwm_pin`

## Requirements
- R1: While rst_n is low, pin_out equals plain_out and frame_start is low, whatever the other inputs are.
- R2: When cfg_load is high with mode_en high, frame_start is high in the next cycle. After that, frame_start is high for one cycle out of every cfg_frame_len+1 cycles.
- R3: In each frame the pin is high for the first N cycles and low for the rest, where N is the on-count in force for that frame. An on-count of 0 gives no high cycle, and an on-count of 1 gives exactly one.
- R4: An on-count greater than the frame length keeps the pin high for the entire frame of cfg_frame_len+1 cycles. This also holds when the frame length is 0.
- R5: A serial word on ser_in (high start bit, 16 data bits MSB first, low stop bit) sets the on-count for the next frame after its stop bit, not for the frame in progress. A stop bit that arrives on the last cycle of a frame still counts only for the frame after the one that follows.
- R6: A serial word whose stop bit is high is discarded, and the held on-count stays unchanged.
- R7: While no new word arrives, every frame reuses the last on-count in force.
- R8: One cycle after mode_en goes low, pin_out equals plain_out and frame_start is low. Operation resumes only after a fresh cfg_load, which starts a new frame from position 0.
- R9: A configuration with cfg_on_valid low sets the on-count to 0, so the pin stays low until a serial word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Keeps the PWM mode alive; low releases the pin |
| cfg_load | input | 1 | One-cycle pulse at the end of a configuration |
| cfg_frame_len | input | 16 | Last frame position; frame lasts this value plus one clocks |
| cfg_on_valid | input | 1 | cfg_on_count is supplied with this configuration |
| cfg_on_count | input | 16 | Initial on-count |
| ser_in | input | 1 | Serial on-count line, idle low |
| plain_out | input | 1 | Pin value used when the mode is inactive |
| pin_out | output | 1 | Pin drive |
| frame_start | output | 1 | High on the first cycle of each frame |

## Verification
The hardest case to reach is a serial stop bit that lands on the same edge as the frame wrap. At that edge the buffer takes the new value while the down counter reloads from the old one. The bench reaches it directly: it waits for the frame position that lies 17 clocks before the wrap and starts a word there. It also reaches it at random, by varying the idle gaps between words and the frame lengths so that stop bits fall on every frame phase. Frame length 0, over-range on-counts, and cancelling the mode part-way through a frame are covered by directed steps.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/fpwm_rx.sv
module fpwm_rx
  import fpwm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ser_in,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      shreg <= '0;
    end else if (!en) begin
      st  <= RX_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        RX_IDLE: begin
          if (ser_in) begin
            st  <= RX_SHIFT;
            cnt <= '0;
          end
        end
        RX_SHIFT: begin
          if (cnt == LAST) begin
            st <= RX_IDLE;
          end else begin
            shreg <= {shreg[DATA_W-2:0], ser_in};
            cnt   <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // stop bit is sampled in the last shift slot; a low line accepts the word
  assign word_valid = en && (st == RX_SHIFT) && (cnt == LAST) && !ser_in;
  assign word_data  = shreg;
endmodule

// File: rtl/fpwm_hold.sv
module fpwm_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         upd,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] held
);
  always_ff @(posedge clk) begin
    if (!rst_n)     held <= '0;
    else if (clear) held <= '0;
    else if (load)  held <= load_val;
    else if (upd)   held <= upd_val;
  end
endmodule

// File: rtl/fpwm_core.sv
module fpwm_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_en,
  input  logic         cfg_load,
  input  logic [W-1:0] cfg_len,
  input  logic [W-1:0] init_on,
  input  logic [W-1:0] held_on,
  output logic         run,
  output logic         drive_hi,
  output logic         frame_start
);
  logic         active;
  logic [W-1:0] pos;
  logic [W-1:0] len_q;
  logic [W:0]   left;

  function automatic logic [W:0] clamp_on(input logic [W-1:0] on, input logic [W-1:0] len);
    if (on > len) return {1'b0, len} + {{W{1'b0}}, 1'b1};
    else          return {1'b0, on};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || !mode_en) begin
      active <= 1'b0;
      pos    <= '0;
      len_q  <= '0;
      left   <= '0;
    end else if (cfg_load) begin
      active <= 1'b1;
      pos    <= '0;
      len_q  <= cfg_len;
      left   <= clamp_on(init_on, cfg_len);
    end else if (active) begin
      if (pos == len_q) begin
        pos  <= '0;
        left <= clamp_on(held_on, len_q);
      end else begin
        pos <= pos + 1'b1;
        if (left != '0) left <= left - 1'b1;
      end
    end
  end

  assign run         = active;
  assign drive_hi    = (left != '0);
  assign frame_start = active && (pos == '0);
endmodule

// File: rtl/frame_pwm_pin.sv
module frame_pwm_pin #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              cfg_load,
  input  logic [DATA_W-1:0] cfg_frame_len,
  input  logic              cfg_on_valid,
  input  logic [DATA_W-1:0] cfg_on_count,
  input  logic              ser_in,
  input  logic              plain_out,
  output logic              pin_out,
  output logic              frame_start
);
  logic              run;
  logic              drive_hi;
  logic              rx_en;
  logic              rx_valid;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] held_on;
  logic [DATA_W-1:0] init_on;

  assign init_on = cfg_on_valid ? cfg_on_count : '0;
  assign rx_en   = run && mode_en && !cfg_load;

  fpwm_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .ser_in(ser_in),
    .word_valid(rx_valid), .word_data(rx_data)
  );

  fpwm_hold #(.W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(!mode_en), .load(cfg_load),
    .load_val(init_on), .upd(rx_valid), .upd_val(rx_data), .held(held_on)
  );

  fpwm_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .cfg_load(cfg_load),
    .cfg_len(cfg_frame_len), .init_on(init_on), .held_on(held_on),
    .run(run), .drive_hi(drive_hi), .frame_start(frame_start)
  );

  assign pin_out = run ? drive_hi : plain_out;
endmodule

// File: rtl/fpwm_chk.sv
module fpwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_en,
  input logic         cfg_load,
  input logic [W-1:0] cfg_frame_len,
  input logic         cfg_on_valid,
  input logic [W-1:0] cfg_on_count,
  input logic         plain_out,
  input logic         pin_out,
  input logic         frame_start,
  input logic         word_valid,
  input logic [W-1:0] word_data,
  input logic [W-1:0] held_on
);
  assert_first_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && cfg_load) |=> frame_start);

  assert_full_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && cfg_load && cfg_on_valid && (cfg_on_count > cfg_frame_len)) |=> pin_out);

  assert_word_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && mode_en && !cfg_load) |=> (held_on == $past(word_data)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> ((pin_out == plain_out) && !frame_start));

  assert_zero_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && cfg_load && !cfg_on_valid) |=> !pin_out);
endmodule

bind frame_pwm_pin fpwm_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .cfg_load(cfg_load),
  .cfg_frame_len(cfg_frame_len), .cfg_on_valid(cfg_on_valid),
  .cfg_on_count(cfg_on_count), .plain_out(plain_out), .pin_out(pin_out),
  .frame_start(frame_start), .word_valid(rx_valid), .word_data(rx_data),
  .held_on(held_on)
);

// File: tb/sim_frame_pwm_pin.sv
`timescale 1ns/1ps
module sim_frame_pwm_pin;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_frame_len = '0;
  logic        cfg_on_valid = 1'b0;
  logic [15:0] cfg_on_count = '0;
  logic        ser_in = 1'b0;
  logic        plain_out = 1'b0;
  logic        pin_out;
  logic        frame_start;

  always #2.5 clk = ~clk;

  frame_pwm_pin u0 (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .cfg_load(cfg_load),
    .cfg_frame_len(cfg_frame_len), .cfg_on_valid(cfg_on_valid),
    .cfg_on_count(cfg_on_count), .ser_in(ser_in), .plain_out(plain_out),
    .pin_out(pin_out), .frame_start(frame_start)
  );

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // reference model state
  bit m_act = 0;
  int m_pos = 0, m_len = 0, m_on = 0, m_buf = 0;
  // serial driver queue
  logic [17:0] sq = '0;
  int sq_left = 0;
  int sq_data = 0;

  function automatic int eff_on(int on, int len);
    return (on > len + 1) ? len + 1 : on;
  endfunction

  task automatic chk(input logic act, input logic exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b time=%0t", t, act, exp, $time);
    end
  endtask

  task automatic step();
    int nb;
    ser_in    = (sq_left > 0) ? sq[17] : 1'b0;
    plain_out = 1'($urandom);
    nb = m_buf;
    if (!rst_n || !mode_en) begin
      m_act = 0; m_pos = 0; m_on = 0; m_len = 0; nb = 0;
    end else if (cfg_load) begin
      m_act = 1; m_pos = 0; m_len = int'(cfg_frame_len);
      nb = cfg_on_valid ? int'(cfg_on_count) : 0;
      m_on = nb;
    end else if (m_act) begin
      if (m_pos == m_len) begin m_pos = 0; m_on = m_buf; end
      else m_pos++;
      if (sq_left == 1 && sq[17] == 1'b0) nb = sq_data;
    end
    m_buf = nb;
    if (sq_left > 0) begin sq = {sq[16:0], 1'b0}; sq_left--; end
    @(negedge clk);
    chk(pin_out, m_act ? 1'(m_pos < eff_on(m_on, m_len)) : plain_out, tag);
    chk(frame_start, 1'(m_act && m_pos == 0), "R2");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_cfg(input int len, input bit vld, input int on);
    cfg_frame_len = 16'(len);
    cfg_on_valid  = vld;
    cfg_on_count  = 16'(on);
    cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
  endtask

  task automatic send_word(input int data, input bit stop);
    sq = {1'b1, 16'(data), stop};
    sq_left = 18;
    sq_data = data & 16'hFFFF;
    while (sq_left > 0) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset holds plain control, even with a configuration applied
    tag = "R1";
    run(3);
    mode_en = 1'b1; cfg_frame_len = 16'd5; cfg_on_valid = 1'b1; cfg_on_count = 16'd2;
    cfg_load = 1'b1; run(2); cfg_load = 1'b0;
    rst_n = 1'b1;
    run(3);

    // R3: basic frame with on-count 3 of a 10-clock frame
    tag = "R3";
    do_cfg(9, 1, 3);
    run(40);
    do_cfg(7, 1, 1);  // one-clock pulse
    run(20);

    // R9: no initial on-count -> pin low
    tag = "R9";
    do_cfg(6, 0, 77);
    run(20);

    // R5: serial update applies at next frame
    tag = "R5";
    send_word(4, 1'b0);
    run(30);

    // R7: value reused without updates
    tag = "R7";
    run(30);

    // R6: bad stop bit discarded
    tag = "R6";
    send_word(6, 1'b1);
    run(30);

    // R4: over-range on-counts
    tag = "R4";
    do_cfg(7, 1, 40);
    run(20);
    send_word(16'hFFFF, 1'b0);
    run(20);
    do_cfg(5, 1, 6);
    run(15);
    do_cfg(0, 1, 2);
    run(6);
    tag = "R3";
    do_cfg(0, 1, 0);
    run(6);

    // R5: stop bit lands on the frame wrap edge
    tag = "R5";
    do_cfg(20, 1, 2);
    while (m_pos != 3) step();
    send_word(11, 1'b0);
    run(50);

    // R8: cancel mid-frame, then stay plain until reconfigured
    tag = "R8";
    do_cfg(9, 1, 8);
    run(3);
    mode_en = 1'b0;
    run(10);
    mode_en = 1'b1;
    run(5);
    do_cfg(4, 1, 2);
    run(12);

    // random phase
    for (int i = 0; i < 40; i++) begin
      int len;
      len = int'($urandom % 24);
      tag = "R3";
      do_cfg(len, 1'($urandom % 2), int'($urandom % (len + 4)));
      for (int j = 0; j < 3; j++) begin
        int d;
        bit s;
        run(int'($urandom % 30));
        d = int'($urandom % (len + 3));
        s = ($urandom % 5) == 0;
        tag = s ? "R6" : "R5";
        send_word(d, s);
      end
      tag = "R7";
      run(2 * (len + 2));
      if ($urandom % 4 == 0) begin
        tag = "R8";
        mode_en = 1'b0;
        run(int'($urandom % 4) + 1);
        mode_en = 1'b1;
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule